// File: doc/BRIEF.md
# Coalescing Host Interrupt Controller

This block gathers device interrupt causes into one 32-bit status word and drives a single level interrupt line toward the host. Hardware sources pulse cause bits high. The host clears them by writing ones over a small 32-bit register bus with byte enables. A separate enable word selects which pending causes may raise the line.

Interrupts are batched. When the first enabled cause appears, the line is held back for a programmable number of ticks. One tick is 32 microseconds, and a built-in prescaler derives it from the core clock. A high-priority receive event skips that wait. A second, independently writable byte sets a period at which the block raises its own receive-periodic cause.

Software sees three words. Offset 0x0 holds the status, which is write-one-to-clear. Offset 0x4 holds the enable mask. Offset 0x8 holds the coalescing controls: bits 7:0 are the delay and bits 15:8 are the period.

Top module: `irq_coal_ctrl`

## Requirements
- R1: A one on `hw_cause_set[i]` at a rising clock edge sets status bit i, read at offset 0x0, from that edge on. The implemented positions are 31 receive DMA, 29 hardware error, 28 receive periodic, 27 transmit DMA, 26 queue pointer advanced, 25 firmware error, 7 radio kill switch, 6 over-temperature, 3 software receive, 1 wakeup and 0 alive.
- R2: A bus write to offset 0x0 clears each status bit whose data bit is 1 within a byte whose enable is set. Zero data bits and disabled bytes leave the status unchanged.
- R3: Positions outside the list in R1 read as 0 in both the status and the enable word, and they never become set.
- R4: If a hardware set and a host clear hit the same status bit at the same edge, the bit ends up set.
- R5: The enable word at offset 0x4 gates the line. A pending cause whose enable bit is 0 never asserts `irq_out`. Enabling such a cause later starts the coalescing sequence from that write.
- R6: At offset 0x8, bits 7:0 hold the delay, which resets to 0x40. Bits 15:8 hold the period, which resets to 0x00. Each byte is written only when its byte enable is set, and bits 31:16 read as 0.
- R7: With a delay D of 1 to 255, `irq_out` rises exactly 1 + D*TICK_CYCLES clock cycles after the edge at which the first enabled cause became pending.
- R8: With a delay of 0, `irq_out` rises at the edge after the one at which an enabled cause became pending.
- R9: Once asserted, `irq_out` stays high while any enabled cause is pending, including after partial acknowledgement. It drops one cycle after the last enabled cause is cleared, and a new delay starts only after that point.
- R10: A pulse on `hi_prio_rx` sets status bit 31. If bit 31 is enabled, `irq_out` rises at the next edge whatever the delay.
- R11: A nonzero period N sets status bit 28 every N*TICK_CYCLES cycles, with the first time counted from the edge that wrote the period byte. A period of 0 never sets bit 28 through this path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_be | input | 4 | Byte enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| hw_cause_set | input | 32 | One-cycle hardware cause pulses, bit per cause |
| hi_prio_rx | input | 1 | High-priority receive event pulse |
| irq_out | output | 1 | Host interrupt line, active high |

## Verification
The assertions assume that cause inputs and `hi_prio_rx` are one-cycle pulses sampled at the clock edge. They also assume that the bus presents at most one write per cycle and that reset is held for at least one edge before activity. The stimulus changes inputs only on the falling edge, keeps every pulse one cycle wide, and holds reset across the first edges. The timing checks use a prescaler of four cycles so that exact rise cycles for the delay and the period can be predicted and sampled.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;

    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    localparam logic [7:0] OFF_STATUS = 8'h00;
    localparam logic [7:0] OFF_ENABLE = 8'h04;
    localparam logic [7:0] OFF_COAL   = 8'h08;

    localparam int BIT_RX_DMA      = 31;
    localparam int BIT_HW_ERR      = 29;
    localparam int BIT_RX_PERIODIC = 28;
    localparam int BIT_TX_DMA      = 27;
    localparam int BIT_QPTR        = 26;
    localparam int BIT_FW_ERR      = 25;
    localparam int BIT_RADIO_KILL  = 7;
    localparam int BIT_OVERTEMP    = 6;
    localparam int BIT_SW_RX       = 3;
    localparam int BIT_WAKE        = 1;
    localparam int BIT_ALIVE       = 0;

    localparam logic [7:0] DELAY_RESET  = 8'h40;
    localparam logic [7:0] PERIOD_RESET = 8'h00;

    typedef enum logic [1:0] {
        CT_IDLE = 2'd0,
        CT_WAIT = 2'd1,
        CT_FIRE = 2'd2
    } coal_state_e;

    typedef struct packed {
        logic [7:0] period;
        logic [7:0] delay;
    } coal_cfg_t;

    function automatic logic [DATA_W-1:0] bit_of(input int idx);
        return DATA_W'(1) << idx;
    endfunction

    function automatic logic [DATA_W-1:0] legal_causes();
        return bit_of(BIT_RX_DMA) | bit_of(BIT_HW_ERR) | bit_of(BIT_RX_PERIODIC)
             | bit_of(BIT_TX_DMA) | bit_of(BIT_QPTR) | bit_of(BIT_FW_ERR)
             | bit_of(BIT_RADIO_KILL) | bit_of(BIT_OVERTEMP) | bit_of(BIT_SW_RX)
             | bit_of(BIT_WAKE) | bit_of(BIT_ALIVE);
    endfunction

    localparam logic [DATA_W-1:0] LEGAL_CAUSES = legal_causes();

    function automatic logic [DATA_W-1:0] be_expand(input logic [BE_W-1:0] be);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < BE_W; i++) begin
            m[8*i +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_tick_prescaler.sv
module irq_tick_prescaler #(
    parameter int CYCLES = 8000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    generate
        if (CYCLES <= 1) begin : g_pass
            assign tick = ~restart;
        end else begin : g_count
            localparam int CW = $clog2(CYCLES);
            localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);
            logic [CW-1:0] cnt_q;

            assign tick = (cnt_q == LAST) && !restart;

            always_ff @(posedge clk) begin
                if (rst || restart) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/irq_cause_status.sv
module irq_cause_status
    import irq_coal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] set_vec,
    input  logic [DATA_W-1:0] clr_vec,
    output logic [DATA_W-1:0] status
);
    logic [DATA_W-1:0] status_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else begin
            status_q <= ((status_q & ~clr_vec) | set_vec) & LEGAL_CAUSES;
        end
    end

    assign status = status_q;

    // R2
    no_clear_no_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_vec == '0) |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R4
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ((set_vec & clr_vec & LEGAL_CAUSES) != '0)
        |=> ((status_q & $past(set_vec & clr_vec & LEGAL_CAUSES))
             == $past(set_vec & clr_vec & LEGAL_CAUSES)));

    // R1
    set_lands_chk: assert property (@(posedge clk) disable iff (rst)
        ((set_vec & LEGAL_CAUSES) != '0)
        |=> ((status_q & $past(set_vec & LEGAL_CAUSES)) == $past(set_vec & LEGAL_CAUSES)));
endmodule

// File: rtl/irq_coal_timer.sv
module irq_coal_timer
    import irq_coal_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pending,
    input  logic       bypass,
    input  logic [7:0] delay,
    input  logic       tick,
    output logic       hold_tick,
    output logic       irq
);
    coal_state_e state_q;
    logic [7:0]  left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CT_IDLE;
            left_q  <= '0;
        end else begin
            unique case (state_q)
                CT_IDLE: begin
                    if (pending) begin
                        if (bypass || delay == 8'd0) begin
                            state_q <= CT_FIRE;
                        end else begin
                            state_q <= CT_WAIT;
                            left_q  <= delay;
                        end
                    end
                end
                CT_WAIT: begin
                    if (!pending) begin
                        state_q <= CT_IDLE;
                    end else if (bypass) begin
                        state_q <= CT_FIRE;
                    end else if (tick) begin
                        if (left_q == 8'd1) begin
                            state_q <= CT_FIRE;
                        end
                        left_q <= left_q - 8'd1;
                    end
                end
                CT_FIRE: begin
                    if (!pending) begin
                        state_q <= CT_IDLE;
                    end
                end
                default: state_q <= CT_IDLE;
            endcase
        end
    end

    assign hold_tick = (state_q != CT_WAIT);
    assign irq       = (state_q == CT_FIRE);

    // R5
    rise_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(pending));

    // R8
    zero_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == CT_IDLE && pending && delay == 8'd0) |=> irq);

    // R10
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (bypass && pending) |=> irq);

    // R9
    hold_while_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && pending) |=> irq);
endmodule

// File: rtl/irq_periodic_gen.sv
module irq_periodic_gen #(
    parameter int TICK_CYCLES = 8000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] period,
    input  logic       reload,
    output logic       fire
);
    logic       tick;
    logic       idle;
    logic [7:0] cnt_q;

    assign idle = reload || (period == 8'd0);

    irq_tick_prescaler #(.CYCLES(TICK_CYCLES)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .restart (idle),
        .tick    (tick)
    );

    assign fire = tick && !idle && (cnt_q == period - 8'd1);

    always_ff @(posedge clk) begin
        if (rst || idle) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= fire ? 8'd0 : cnt_q + 8'd1;
        end
    end

    // R11
    period_off_silent_chk: assert property (@(posedge clk) disable iff (rst)
        fire |-> (period != 8'd0));
endmodule

// File: rtl/irq_coal_ctrl.sv
module irq_coal_ctrl
    import irq_coal_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int TICK_CYCLES = 8000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] hw_cause_set,
    input  logic              hi_prio_rx,
    output logic              irq_out
);
    logic [DATA_W-1:0] be_bits;
    logic              wr_status, wr_enable, wr_coal;
    logic [DATA_W-1:0] clr_vec, set_vec, status;
    logic [DATA_W-1:0] enable_q;
    coal_cfg_t         cfg_q;
    logic              periodic_fire, reload_period;
    logic              bypass_q;
    logic              pending_en;
    logic              coal_tick, hold_tick;

    assign be_bits   = be_expand(bus_be);
    assign wr_status = bus_we && (bus_addr == ADDR_W'(OFF_STATUS));
    assign wr_enable = bus_we && (bus_addr == ADDR_W'(OFF_ENABLE));
    assign wr_coal   = bus_we && (bus_addr == ADDR_W'(OFF_COAL));

    assign clr_vec = wr_status ? (bus_wdata & be_bits) : '0;
    assign set_vec = hw_cause_set
                   | ({DATA_W{hi_prio_rx}}    & bit_of(BIT_RX_DMA))
                   | ({DATA_W{periodic_fire}} & bit_of(BIT_RX_PERIODIC));

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q     <= '0;
            cfg_q.delay  <= DELAY_RESET;
            cfg_q.period <= PERIOD_RESET;
            bypass_q     <= 1'b0;
        end else begin
            bypass_q <= hi_prio_rx;
            if (wr_enable) begin
                enable_q <= ((enable_q & ~be_bits) | (bus_wdata & be_bits)) & LEGAL_CAUSES;
            end
            if (wr_coal && bus_be[0]) begin
                cfg_q.delay <= bus_wdata[7:0];
            end
            if (wr_coal && bus_be[1]) begin
                cfg_q.period <= bus_wdata[15:8];
            end
        end
    end

    assign reload_period = wr_coal && bus_be[1];

    irq_cause_status u_status (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .status  (status)
    );

    irq_periodic_gen #(.TICK_CYCLES(TICK_CYCLES)) u_periodic (
        .clk    (clk),
        .rst    (rst),
        .period (cfg_q.period),
        .reload (reload_period),
        .fire   (periodic_fire)
    );

    irq_tick_prescaler #(.CYCLES(TICK_CYCLES)) u_coal_tick (
        .clk     (clk),
        .rst     (rst),
        .restart (hold_tick),
        .tick    (coal_tick)
    );

    assign pending_en = |(status & enable_q);

    irq_coal_timer u_timer (
        .clk       (clk),
        .rst       (rst),
        .pending   (pending_en),
        .bypass    (bypass_q),
        .delay     (cfg_q.delay),
        .tick      (coal_tick),
        .hold_tick (hold_tick),
        .irq       (irq_out)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_STATUS)) begin
            bus_rdata = status;
        end else if (bus_addr == ADDR_W'(OFF_ENABLE)) begin
            bus_rdata = enable_q;
        end else if (bus_addr == ADDR_W'(OFF_COAL)) begin
            bus_rdata = {16'h0000, cfg_q};
        end
    end

    // R10
    hi_prio_sets_rx_chk: assert property (@(posedge clk) disable iff (rst)
        hi_prio_rx |=> status[BIT_RX_DMA]);

    // R3
    enable_legal_chk: assert property (@(posedge clk) disable iff (rst)
        wr_enable |=> ((enable_q & ~LEGAL_CAUSES) == '0));
endmodule

// File: tb/irq_coal_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_coal_ctrl_tb_top;
    localparam int P = 4;
    localparam logic [31:0] LEGAL = 32'hBE0000CB;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] hw_cause_set = '0;
    logic        hi_prio_rx = 1'b0;
    logic        irq_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    irq_coal_ctrl #(.ADDR_W(4), .TICK_CYCLES(P)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_be       (bus_be),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .hw_cause_set (hw_cause_set),
        .hi_prio_rx   (hi_prio_rx),
        .irq_out      (irq_out)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_be = '0;
    endtask

    task automatic pulse(input logic [31:0] c);
        hw_cause_set = c;
        @(negedge clk);
        hw_cause_set = '0;
    endtask

    task automatic clean(input logic [7:0] delay);
        wr(4'h4, 4'hF, 32'h0);
        wr(4'h8, 4'hF, {24'h0, delay});
        wr(4'h0, 4'hF, 32'hFFFF_FFFF);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(4'h0, d); chk("R1", "status after reset", d, 32'h0);
        rd(4'h4, d); chk("R5", "enable after reset", d, 32'h0);
        rd(4'h8, d); chk("R6", "coal after reset", d, 32'h0000_0040);
        chk("R9", "irq after reset", {31'h0, irq_out}, 32'h0);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        clean(8'h40);
        pulse(32'h0C00_0009);
        rd(4'h0, d); chk("R1", "status set", d, 32'h0C00_0009);
        wr(4'h0, 4'hF, 32'h0800_0001);
        rd(4'h0, d); chk("R2", "partial clear", d, 32'h0400_0008);
        wr(4'h0, 4'hF, 32'h0);
        rd(4'h0, d); chk("R2", "zero write no effect", d, 32'h0400_0008);
        wr(4'h0, 4'h7, 32'hFFFF_FFFF);
        rd(4'h0, d); chk("R2", "byte-enable masked clear", d, 32'h0400_0000);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        clean(8'h40);
        pulse(32'hFFFF_FFFF);
        rd(4'h0, d); chk("R3", "only legal bits set", d, LEGAL);
        wr(4'h4, 4'hF, 32'hFFFF_FFFF);
        rd(4'h4, d); chk("R3", "enable legal bits", d, LEGAL);
        wr(4'h4, 4'hF, 32'h0);
        wr(4'h0, 4'h1, 32'hFFFF_FFFF);
        rd(4'h0, d); chk("R2", "byte0 clear only", d, 32'hBE00_0000);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        clean(8'h40);
        hw_cause_set = 32'h0000_0001;
        wr(4'h0, 4'hF, 32'h0000_0001);
        hw_cause_set = '0;
        rd(4'h0, d); chk("R4", "set beats clear", d, 32'h0000_0001);
    endtask

    task automatic t_coal_bytes();
        logic [31:0] d;
        clean(8'h40);
        wr(4'h8, 4'h2, 32'hFFFF_0355);
        rd(4'h8, d); chk("R6", "period byte alone", d, 32'h0000_0340);
        wr(4'h8, 4'h1, 32'hFFFF_0022);
        rd(4'h8, d); chk("R6", "delay byte alone", d, 32'h0000_0322);
        wr(4'h8, 4'h2, 32'h0);
    endtask

    task automatic t_zero_delay();
        clean(8'h00);
        wr(4'h4, 4'hF, 32'h0000_0001);
        pulse(32'h0000_0001);
        chk("R8", "irq same cycle", {31'h0, irq_out}, 32'h0);
        @(negedge clk);
        chk("R8", "irq next cycle", {31'h0, irq_out}, 32'h1);
    endtask

    task automatic t_masked();
        clean(8'h00);
        pulse(32'h0000_0002);
        repeat (6) @(negedge clk);
        chk("R5", "masked cause silent", {31'h0, irq_out}, 32'h0);
        wr(4'h4, 4'hF, 32'h0000_0002);
        @(negedge clk);
        chk("R5", "irq after enabling", {31'h0, irq_out}, 32'h1);
    endtask

    task automatic t_delay();
        clean(8'h03);
        wr(4'h4, 4'hF, 32'h0000_0001);
        pulse(32'h0000_0001);
        repeat (12) @(negedge clk);
        chk("R7", "irq held before expiry", {31'h0, irq_out}, 32'h0);
        @(negedge clk);
        chk("R7", "irq at expiry", {31'h0, irq_out}, 32'h1);
    endtask

    task automatic t_hold();
        clean(8'h00);
        wr(4'h4, 4'hF, 32'h0000_0003);
        pulse(32'h0000_0003);
        @(negedge clk);
        chk("R9", "irq raised", {31'h0, irq_out}, 32'h1);
        wr(4'h0, 4'hF, 32'h0000_0001);
        repeat (4) @(negedge clk);
        chk("R9", "irq held on partial ack", {31'h0, irq_out}, 32'h1);
        wr(4'h0, 4'hF, 32'h0000_0002);
        @(negedge clk);
        chk("R9", "irq dropped after full ack", {31'h0, irq_out}, 32'h0);
    endtask

    task automatic t_bypass();
        logic [31:0] d;
        clean(8'h40);
        wr(4'h4, 4'hF, 32'h8000_0000);
        hi_prio_rx = 1'b1;
        @(negedge clk);
        hi_prio_rx = 1'b0;
        rd(4'h0, d); chk("R10", "bit 31 set", d, 32'h8000_0000);
        chk("R10", "irq not yet", {31'h0, irq_out}, 32'h0);
        @(negedge clk);
        chk("R10", "irq bypasses delay", {31'h0, irq_out}, 32'h1);
    endtask

    task automatic t_periodic();
        logic [31:0] d;
        clean(8'h40);
        wr(4'h8, 4'h2, 32'h0000_0200);
        repeat (7) @(negedge clk);
        rd(4'h0, d); chk("R11", "bit 28 before period", d, 32'h0);
        @(negedge clk);
        rd(4'h0, d); chk("R11", "bit 28 at period", d, 32'h1000_0000);
        wr(4'h8, 4'h2, 32'h0);
        wr(4'h0, 4'hF, 32'hFFFF_FFFF);
        repeat (40) @(negedge clk);
        rd(4'h0, d); chk("R11", "period zero silent", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_w1c();
        t_reserved();
        t_set_wins();
        t_coal_bytes();
        t_zero_delay();
        t_masked();
        t_delay();
        t_hold();
        t_bypass();
        t_periodic();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule